// File: doc/BRIEF.md
# Plane-to-Pixel Serializer with Selectable Shift Modes

This block sits in a display pipeline between the video memory fetch and the palette lookup. At each character time, it receives one 32-bit word that holds one byte from each of four bit planes, all read at the same display address. It then emits eight 4-bit pixel values, one for each enabled dot clock. Plane n occupies bits [8n+7:8n] of the word.

Two mode bits select how bits are gathered across the planes:

- **Single shift** draws one bit from every plane for each pixel.
- **Interleaved shift** draws two-bit pairs from planes 0 and 2 for the first four pixels, then from planes 1 and 3.
- **256-colour shift** draws whole nibbles, one plane after another.

The 256-colour bit wins when both mode bits are set. The mode is captured together with the word, so changes to the mode bits in the middle of a byte have no effect. A load that lands on the same enabled dot as the eighth pixel chains straight into the next byte with no idle dot.

Top module: `plane_serializer`

## Requirements
- R1: While reset is held and after release with no load, `pix_valid_o` is 0 and `pix_o` is 0.
- R2: A clock edge with `load_i` and `dot_en_i` both high captures the word, and the output shows pixel 0 of that word with `pix_valid_o` at 1 right after that edge. `load_i` without `dot_en_i` is ignored.
- R3: With both mode bits clear, bit n of pixel k is bit 7-k of plane n, for k from 0 to 7.
- R4: With only the interleave bit set, pixel k for k from 0 to 3 is {plane2[7-2k], plane2[6-2k], plane0[7-2k], plane0[6-2k]}, MSB first. Pixels 4 to 7 follow the same pattern using plane 3 in place of plane 2 and plane 1 in place of plane 0, with k-4 in place of k.
- R5: With the 256-colour bit set, pixel k comes from plane k/2. Even k uses bits [7:4] of that plane and odd k uses bits [3:0].
- R6: With both mode bits set, the output equals the 256-colour pattern of R5.
- R7: The output advances by one pixel only on edges where `dot_en_i` is high. With `dot_en_i` low, `pix_o` and `pix_valid_o` hold.
- R8: The enabled edge after pixel 7 with no load drops `pix_valid_o` to 0 and `pix_o` to 0.
- R9: A load on the enabled edge that retires pixel 7 shows pixel 0 of the new word on the next cycle, with `pix_valid_o` staying at 1.
- R10: A load before pixel 7 abandons the current byte and restarts at pixel 0 of the new word.
- R11: The mode bits are sampled only on load. Changes in the middle of a byte do not alter the remaining pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel-domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dot_en_i | input | 1 | Dot clock enable; one pixel per enabled edge |
| load_i | input | 1 | Capture `planes_i` and the mode bits (qualified by `dot_en_i`) |
| planes_i | input | 32 | Plane bytes; plane n in bits [8n+7:8n] |
| shift256_i | input | 1 | 256-colour shift select (highest priority) |
| shift_ilv_i | input | 1 | Interleaved shift select |
| pix_o | output | 4 | Current pixel value, 0 when not valid |
| pix_valid_o | output | 1 | `pix_o` carries a pixel |

## Verification
Every result appears one register stage after the enabled edge that causes it. A load shows pixel 0 right after its edge, each further enabled edge shows the next pixel, and the edge after pixel 7 clears the valid flag. The bench drives inputs on the falling edge and checks the outputs on the following falling edge. Each check therefore sees exactly the state produced by the single rising edge in between. Hold, back-to-back and restart cases are counted dot by dot against a reference model of the three patterns.

// File: rtl/plane_ser_pkg.sv
package plane_ser_pkg;
  localparam int unsigned PLANES  = 4;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned WORD_W  = PLANES * BYTE_W;
  localparam int unsigned PIX_W   = PLANES;
  localparam int unsigned DOTS    = BYTE_W;
  localparam int unsigned IDX_W   = $clog2(DOTS);

  typedef enum logic [1:0] {
    SH_SINGLE = 2'd0,
    SH_ILV    = 2'd1,
    SH_256    = 2'd2
  } shift_mode_e;
endpackage

// File: rtl/plane_ser_mode_dec.sv
module plane_ser_mode_dec
  import plane_ser_pkg::*;
(
  input  logic        shift256_i,
  input  logic        shift_ilv_i,
  output shift_mode_e mode_o
);
  // 256-colour shift wins over interleave
  always_comb begin
    if (shift256_i)       mode_o = SH_256;
    else if (shift_ilv_i) mode_o = SH_ILV;
    else                  mode_o = SH_SINGLE;
  end
endmodule

// File: rtl/plane_ser_ctrl.sv
module plane_ser_ctrl
  import plane_ser_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dot_en_i,
  input  logic               load_i,
  input  logic [WORD_W-1:0]  planes_i,
  input  shift_mode_e        mode_i,
  output logic [WORD_W-1:0]  word_o,
  output shift_mode_e        mode_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               valid_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DOTS - 1);

  logic take;
  assign take = dot_en_i && load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o  <= '0;
      mode_o  <= SH_SINGLE;
      idx_o   <= '0;
      valid_o <= 1'b0;
    end else if (take) begin
      word_o  <= planes_i;
      mode_o  <= mode_i;
      idx_o   <= '0;
      valid_o <= 1'b1;
    end else if (dot_en_i && valid_o) begin
      if (idx_o == LAST) begin
        valid_o <= 1'b0;
        idx_o   <= '0;
      end else begin
        idx_o   <= idx_o + 1'b1;
      end
    end
  end

  AST_LOAD_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dot_en_i && load_i) |=> (valid_o && idx_o == '0)); // R2
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dot_en_i && !load_i && valid_o && idx_o != LAST) |=> (valid_o && idx_o == $past(idx_o) + 1'b1)); // R7
  AST_HOLD_NO_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dot_en_i |=> ($stable(idx_o) && $stable(valid_o) && $stable(word_o))); // R7
  AST_LAST_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dot_en_i && !load_i && valid_o && idx_o == LAST) |=> !valid_o); // R8
  AST_CHAIN_NO_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dot_en_i && load_i && valid_o && idx_o == LAST) |=> (valid_o && idx_o == '0)); // R9
endmodule

// File: rtl/plane_ser_pix_mux.sv
module plane_ser_pix_mux
  import plane_ser_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  shift_mode_e       mode_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              valid_i,
  output logic [PIX_W-1:0]  pix_o
);
  logic [BYTE_W-1:0] pl [PLANES];
  logic [PIX_W-1:0]  sgl;
  logic [PIX_W-1:0]  ilv;
  logic [PIX_W-1:0]  c256;

  for (genvar n = 0; n < PLANES; n++) begin : g_plane
    assign pl[n]  = word_i[n*BYTE_W +: BYTE_W];
    // single shift: MSB first, plane n feeds pixel bit n
    assign sgl[n] = pl[n][3'd7 - idx_i];
  end

  // interleaved: pairs from planes 0/2, then 1/3
  logic [2:0] ph, plo;
  logic [1:0] lo_p, hi_p;
  assign ph   = 3'd7 - {idx_i[1:0], 1'b0};
  assign plo  = ph - 3'd1;
  assign lo_p = {1'b0, idx_i[2]};
  assign hi_p = {1'b1, idx_i[2]};
  assign ilv  = {pl[hi_p][ph], pl[hi_p][plo], pl[lo_p][ph], pl[lo_p][plo]};

  // 256-colour: high nibble then low nibble, plane by plane
  logic [1:0] np;
  assign np   = idx_i[2:1];
  assign c256 = idx_i[0] ? pl[np][3:0] : pl[np][7:4];

  always_comb begin
    unique case (mode_i)
      SH_ILV:  pix_o = ilv;
      SH_256:  pix_o = c256;
      default: pix_o = sgl;
    endcase
    if (!valid_i) pix_o = '0;
  end
endmodule

// File: rtl/plane_serializer.sv
module plane_serializer
  import plane_ser_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dot_en_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] planes_i,
  input  logic              shift256_i,
  input  logic              shift_ilv_i,
  output logic [PIX_W-1:0]  pix_o,
  output logic              pix_valid_o
);
  shift_mode_e       mode_in, mode_q;
  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;

  plane_ser_mode_dec u_dec (
    .shift256_i (shift256_i),
    .shift_ilv_i(shift_ilv_i),
    .mode_o     (mode_in)
  );

  plane_ser_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dot_en_i(dot_en_i),
    .load_i  (load_i),
    .planes_i(planes_i),
    .mode_i  (mode_in),
    .word_o  (word_q),
    .mode_o  (mode_q),
    .idx_o   (idx_q),
    .valid_o (pix_valid_o)
  );

  plane_ser_pix_mux u_mux (
    .word_i (word_q),
    .mode_i (mode_q),
    .idx_i  (idx_q),
    .valid_i(pix_valid_o),
    .pix_o  (pix_o)
  );

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_o |-> (pix_o == '0)); // R8
  AST_MODE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dot_en_i && load_i) |=> (mode_q == $past(mode_q))); // R11
endmodule

// File: tb/plane_serializer_tb_top.sv
`timescale 1ns/100ps
module plane_serializer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dot_en = 1'b0;
  logic        load = 1'b0;
  logic [31:0] planes = '0;
  logic        s256 = 1'b0;
  logic        silv = 1'b0;
  logic [3:0]  pix;
  logic        pvalid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  plane_serializer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dot_en_i(dot_en), .load_i(load),
    .planes_i(planes), .shift256_i(s256), .shift_ilv_i(silv),
    .pix_o(pix), .pix_valid_o(pvalid)
  );

  function automatic logic [3:0] model(logic [31:0] w, logic a, logic b, int k);
    logic [3:0] r;
    if (a) begin
      int p = k / 2;
      r = (k % 2) ? w[p*8 +: 4] : w[p*8+4 +: 4];
    end else if (b) begin
      int h = k / 4;
      int j = k % 4;
      int pos = 7 - 2*j;
      int lo = h;
      int hi = 2 + h;
      r = {w[hi*8+pos], w[hi*8+pos-1], w[lo*8+pos], w[lo*8+pos-1]};
    end else begin
      for (int n = 0; n < 4; n++) r[n] = w[n*8 + 7 - k];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(bit en);
    dot_en = en;
    @(negedge clk);
    dot_en = 1'b0;
  endtask

  task automatic do_load(logic [31:0] w, logic a, logic b);
    load = 1'b1; planes = w; s256 = a; silv = b; dot_en = 1'b1;
    @(negedge clk);
    load = 1'b0; dot_en = 1'b0;
  endtask

  // checks pixels from..7, stepping between them; leaves output on pixel 7
  task automatic check_pixels(string tag, logic [31:0] w, logic a, logic b, int from);
    for (int k = from; k < 8; k++) begin
      check({tag, " valid"}, {3'b0, pvalid}, 4'd1);
      check(tag, pix, model(w, a, b, k));
      if (k < 7) step(1'b1);
    end
  endtask

  task automatic check_idle_after(string tag);
    step(1'b1);
    check({tag, " R8 valid"}, {3'b0, pvalid}, 4'd0);
    check({tag, " R8 pix"}, pix, 4'd0);
  endtask

  task automatic t_reset;
    check("R1 valid in reset", {3'b0, pvalid}, 4'd0);
    check("R1 pix in reset", pix, 4'd0);
    rst_n = 1'b1;
    @(negedge clk);
    step(1'b1);
    check("R1 valid idle", {3'b0, pvalid}, 4'd0);
    load = 1'b1; planes = 32'hFFFF_FFFF;
    @(negedge clk);
    load = 1'b0;
    check("R2 load w/o enable ignored", {3'b0, pvalid}, 4'd0);
  endtask

  task automatic t_single;
    do_load(32'h0F_33_55_A5, 1'b0, 1'b0);
    check_pixels("R3 single", 32'h0F_33_55_A5, 1'b0, 1'b0, 0);
    check_idle_after("single");
    do_load(32'h80_01_7E_C3, 1'b0, 1'b0);
    check_pixels("R2 R3 single b", 32'h80_01_7E_C3, 1'b0, 1'b0, 0);
    check_idle_after("single b");
  endtask

  task automatic t_ilv;
    do_load(32'hE4_1B_C6_39, 1'b0, 1'b1);
    check_pixels("R4 interleaved", 32'hE4_1B_C6_39, 1'b0, 1'b1, 0);
    check_idle_after("ilv");
  endtask

  task automatic t_256;
    do_load(32'h76_54_32_10, 1'b1, 1'b0);
    check_pixels("R5 256", 32'h76_54_32_10, 1'b1, 1'b0, 0);
    check_idle_after("256");
  endtask

  task automatic t_both;
    do_load(32'h9D_2C_E1_4B, 1'b1, 1'b1);
    check_pixels("R6 both bits", 32'h9D_2C_E1_4B, 1'b1, 1'b0, 0);
    check_idle_after("both");
  endtask

  task automatic t_stall;
    logic [31:0] w = 32'h5A_C3_96_0F;
    do_load(w, 1'b0, 1'b0);
    step(1'b1);
    for (int i = 0; i < 3; i++) begin
      step(1'b0);
      check("R7 hold without enable", pix, model(w, 1'b0, 1'b0, 1));
      check("R7 valid held", {3'b0, pvalid}, 4'd1);
    end
    step(1'b1);
    check("R7 advance after stall", pix, model(w, 1'b0, 1'b0, 2));
    check_pixels("R7 rest", w, 1'b0, 1'b0, 2);
    check_idle_after("stall");
  endtask

  task automatic t_b2b;
    logic [31:0] w1 = 32'h12_34_56_78;
    logic [31:0] w2 = 32'hF0_E1_D2_C3;
    do_load(w1, 1'b0, 1'b1);
    check_pixels("R9 first byte", w1, 1'b0, 1'b1, 0);
    do_load(w2, 1'b1, 1'b0);
    check("R9 no gap valid", {3'b0, pvalid}, 4'd1);
    check_pixels("R9 second byte", w2, 1'b1, 1'b0, 0);
    check_idle_after("b2b");
  endtask

  task automatic t_restart;
    logic [31:0] w1 = 32'hAA_55_AA_55;
    logic [31:0] w2 = 32'h3C_C3_81_7E;
    do_load(w1, 1'b0, 1'b0);
    step(1'b1); step(1'b1); step(1'b1);
    check("R10 mid byte", pix, model(w1, 1'b0, 1'b0, 3));
    do_load(w2, 1'b0, 1'b1);
    check_pixels("R10 restart", w2, 1'b0, 1'b1, 0);
    check_idle_after("restart");
  endtask

  task automatic t_mode_hold;
    logic [31:0] w = 32'hB7_48_E9_16;
    do_load(w, 1'b0, 1'b0);
    s256 = 1'b1; silv = 1'b1;
    step(1'b1);
    check("R11 mode change ignored", pix, model(w, 1'b0, 1'b0, 1));
    s256 = 1'b0; silv = 1'b1;
    check_pixels("R11 rest single", w, 1'b0, 1'b0, 1);
    check_idle_after("mode hold");
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset;
    t_single;
    t_ilv;
    t_256;
    t_both;
    t_stall;
    t_b2b;
    t_restart;
    t_mode_hold;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule